// File: doc/BRIEF.md
# Multilevel Pipeline Register Bank

This block holds four byte-wide storage stages, called A1, A2, B1 and B2. All four are fed from one shared data input. A 2-bit operation code is sampled at every rising clock edge and decides how data moves through the stages. The stages can behave as one chain four deep, or as two separate chains two deep (the A side and the B side). They can also keep their contents unchanged.

A 2-bit read select picks one stage and drives it onto the output bus. This path is combinational, so reading never disturbs the stored data. An active-low output enable controls the bus. Instead of a real three-state driver, the block raises a valid flag when the bus is driven and forces the data to zero when it is not. A typical use is to capture a burst of words and play it back from any depth of the pipeline.

Top module: `mlpr_bank`

## Requirements
- R1: While `rst_n` is low, all four stages are cleared to zero asynchronously. After reset, every select value reads back 0.
- R2: Operation code 0 shifts the whole chain at each rising edge: `din` goes into A1, A1 into A2, A2 into B1 and B1 into B2.
- R3: Operation code 1 loads `din` into B1 and moves B1 into B2. A1 and A2 keep their values.
- R4: Operation code 2 loads `din` into A1 and moves A1 into A2. B1 and B2 keep their values.
- R5: Operation code 3 leaves all four stages unchanged, whatever is on `din`.
- R6: `sel` maps to stages combinationally, with no clock involved: 0 reads B2, 1 reads B1, 2 reads A2 and 3 reads A1.
- R7: When `oe_n` is high, `dout_vld` is 0 and `dout` is 0. When `oe_n` is low, `dout_vld` is 1 and `dout` carries the selected stage.
- R8: Changing `sel` or `oe_n` never changes any stored stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op | input | 2 | Operation code: 0 chain shift, 1 B side, 2 A side, 3 hold |
| din | input | WIDTH | Shared data input |
| sel | input | 2 | Read select: 0 B2, 1 B1, 2 A2, 3 A1 |
| oe_n | input | 1 | Active-low output enable |
| dout | output | WIDTH | Selected stage, or zero when disabled |
| dout_vld | output | 1 | High when the output bus is driven |

## Verification
First, a directed run fills the chain with distinct bytes using code 0. It then reads all four selects, which separates stage order from select decoding. Next, the two-deep codes are run with data that differs from what is stored, so a side that should hold but moves shows up at once. The hold code is then driven with changing data, and the selects and enable are swept with the clock held. Finally, a long random mix of codes, data, selects and enables is compared against a four-stage reference model.

// File: rtl/mlpr_pkg.sv
package mlpr_pkg;
  typedef enum logic [1:0] {
    OP_CHAIN  = 2'd0,
    OP_BSIDE  = 2'd1,
    OP_ASIDE  = 2'd2,
    OP_FREEZE = 2'd3
  } op_e;

  localparam int NSTAGE = 4;
  localparam int IDX_A1 = 0;
  localparam int IDX_A2 = 1;
  localparam int IDX_B1 = 2;
  localparam int IDX_B2 = 3;
endpackage

// File: rtl/mlpr_ctrl.sv
module mlpr_ctrl
  import mlpr_pkg::*;
(
  input  op_e                op,
  output logic [NSTAGE-1:0]  ld_en,
  output logic               b1_take_din
);
  always_comb begin
    ld_en       = '0;
    b1_take_din = 1'b0;
    unique case (op)
      OP_CHAIN:  ld_en = '1;
      OP_BSIDE: begin
        ld_en[IDX_B1] = 1'b1;
        ld_en[IDX_B2] = 1'b1;
        b1_take_din   = 1'b1;
      end
      OP_ASIDE: begin
        ld_en[IDX_A1] = 1'b1;
        ld_en[IDX_A2] = 1'b1;
      end
      default: ld_en = '0;
    endcase
  end
endmodule

// File: rtl/mlpr_stage.sv
module mlpr_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/mlpr_outmux.sv
module mlpr_outmux
  import mlpr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSTAGE*WIDTH-1:0] stages,
  input  logic [1:0]              sel,
  input  logic                    oe_n,
  output logic [WIDTH-1:0]        dout,
  output logic                    dout_vld
);
  logic [1:0]       idx;
  logic [WIDTH-1:0] picked;

  // select 0 reads the deepest stage, 3 the first
  always_comb begin
    idx    = ~sel;
    picked = stages[idx*WIDTH +: WIDTH];
    dout_vld = ~oe_n;
    dout     = oe_n ? '0 : picked;
  end

  p_oe_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dout_vld && dout == '0));
  p_oe_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> dout_vld);
endmodule

// File: rtl/mlpr_bank.sv
module mlpr_bank
  import mlpr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] din,
  input  logic [1:0]       sel,
  input  logic             oe_n,
  output logic [WIDTH-1:0] dout,
  output logic             dout_vld
);
  localparam int BUSW = NSTAGE * WIDTH;

  logic [NSTAGE-1:0] ld_en;
  logic              b1_take_din;
  logic [WIDTH-1:0]  src [NSTAGE];
  logic [WIDTH-1:0]  q   [NSTAGE];
  logic [BUSW-1:0]   q_bus;

  mlpr_ctrl u_ctrl (
    .op          (op_e'(op)),
    .ld_en       (ld_en),
    .b1_take_din (b1_take_din)
  );

  always_comb begin
    src[IDX_A1] = din;
    src[IDX_A2] = q[IDX_A1];
    src[IDX_B1] = b1_take_din ? din : q[IDX_A2];
    src[IDX_B2] = q[IDX_B1];
  end

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    mlpr_stage #(.WIDTH(WIDTH)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ld_en[g]),
      .d     (src[g]),
      .q     (q[g])
    );
    assign q_bus[g*WIDTH +: WIDTH] = q[g];
  end

  mlpr_outmux #(.WIDTH(WIDTH)) u_outmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .stages   (q_bus),
    .sel      (sel),
    .oe_n     (oe_n),
    .dout     (dout),
    .dout_vld (dout_vld)
  );

  p_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd0) |=> (q[IDX_A1] == $past(din) && q[IDX_A2] == $past(q[IDX_A1]) &&
                      q[IDX_B1] == $past(q[IDX_A2]) && q[IDX_B2] == $past(q[IDX_B1])));
  p_bside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd1) |=> (q[IDX_B1] == $past(din) && q[IDX_B2] == $past(q[IDX_B1]) &&
                      $stable(q[IDX_A1]) && $stable(q[IDX_A2])));
  p_aside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd2) |=> (q[IDX_A1] == $past(din) && q[IDX_A2] == $past(q[IDX_A1]) &&
                      $stable(q[IDX_B1]) && $stable(q[IDX_B2])));
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd3) |=> ($stable(q[IDX_A1]) && $stable(q[IDX_A2]) &&
                      $stable(q[IDX_B1]) && $stable(q[IDX_B2])));
endmodule

// File: tb/test_mlpr_bank.sv
module test_mlpr_bank;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] data;
    logic         vld;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   op;
  logic [W-1:0] din;
  logic [1:0]   sel;
  logic         oe_n;
  logic [W-1:0] dout;
  logic         dout_vld;

  int checks = 0;
  int errors = 0;
  exp_t sb [$];
  logic [W-1:0] m [4];  // 0 A1, 1 A2, 2 B1, 3 B2
  bit done = 0;

  always #10 clk = ~clk;

  mlpr_bank #(.WIDTH(W)) i_mlpr_bank (
    .clk(clk), .rst_n(rst_n), .op(op), .din(din), .sel(sel),
    .oe_n(oe_n), .dout(dout), .dout_vld(dout_vld)
  );

  function automatic logic [W-1:0] pick(input logic [1:0] s);
    case (s)
      2'd0: pick = m[3];
      2'd1: pick = m[2];
      2'd2: pick = m[1];
      default: pick = m[0];
    endcase
  endfunction

  task automatic compare(input string tag, input logic [W-1:0] ed, input logic ev);
    checks++;
    if (dout !== ed || dout_vld !== ev) begin
      errors++;
      $display("FAIL %s dout=%h vld=%b expected dout=%h vld=%b", tag, dout, dout_vld, ed, ev);
    end
  endtask

  // driver: apply one clocked step and push the expected output after the edge
  task automatic step(input logic [1:0] o, input logic [W-1:0] d,
                      input logic [1:0] s, input logic oe, input string tag);
    exp_t e;
    @(negedge clk);
    op = o; din = d; sel = s; oe_n = oe;
    case (o)
      2'd0: begin m[3] = m[2]; m[2] = m[1]; m[1] = m[0]; m[0] = d; end
      2'd1: begin m[3] = m[2]; m[2] = d; end
      2'd2: begin m[1] = m[0]; m[0] = d; end
      default: ;
    endcase
    e.data = oe ? '0 : pick(s);
    e.vld  = ~oe;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // monitor: compare 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        compare(e.tag, e.data, e.vld);
      end
    end
  end

  // combinational read with clock held in freeze
  task automatic peek_all(input string tag);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      op = 2'd3; sel = 2'(s); oe_n = 1'b0;
      #2;
      compare(tag, pick(2'(s)), 1'b1);
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op = 2'd0; din = 8'hff; sel = 2'd0; oe_n = 1'b0;
    for (int i = 0; i < 4; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s); #1;
      compare("R1 reset", '0, 1'b1);
    end
    @(negedge clk);
    op = 2'd3; rst_n = 1'b1;
    peek_all("R1 after release");

    // R2: fill chain
    step(2'd0, 8'h11, 2'd3, 1'b0, "R2");
    step(2'd0, 8'h22, 2'd2, 1'b0, "R2");
    step(2'd0, 8'h33, 2'd1, 1'b0, "R2");
    step(2'd0, 8'h44, 2'd0, 1'b0, "R2");
    step(2'd3, 8'h99, 2'd0, 1'b0, "R5");
    @(posedge clk); #6;
    peek_all("R6 select map");
    // R3: B side only
    step(2'd1, 8'hb1, 2'd1, 1'b0, "R3");
    step(2'd1, 8'hb2, 2'd0, 1'b0, "R3");
    step(2'd3, 8'h00, 2'd3, 1'b0, "R3 A1 held");
    step(2'd3, 8'h00, 2'd2, 1'b0, "R3 A2 held");
    // R4: A side only
    step(2'd2, 8'ha1, 2'd3, 1'b0, "R4");
    step(2'd2, 8'ha2, 2'd2, 1'b0, "R4");
    step(2'd3, 8'h5a, 2'd1, 1'b0, "R4 B1 held");
    step(2'd3, 8'h5a, 2'd0, 1'b0, "R4 B2 held");
    // R5: freeze with changing data
    for (int k = 0; k < 6; k++) step(2'd3, 8'(k * 37 + 1), 2'(k), 1'b0, "R5");
    // R7: disabled output
    step(2'd3, 8'h00, 2'd3, 1'b1, "R7 disabled");
    step(2'd0, 8'h77, 2'd0, 1'b1, "R7 disabled shift");
    step(2'd3, 8'h00, 2'd3, 1'b0, "R7 enabled");
    @(posedge clk); #6;
    // R8: sweeping sel/oe_n with clock held must not alter contents
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      op = 2'd3; sel = 2'(k); oe_n = k[0];
    end
    @(posedge clk); #6;
    peek_all("R8 contents intact");
    // random mix against the model
    for (int k = 0; k < 400; k++) begin
      logic [1:0] o;
      o = 2'($urandom_range(0, 3));
      step(o, 8'($urandom), 2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0),
           o == 2'd0 ? "R2 rnd" : o == 2'd1 ? "R3 rnd" : o == 2'd2 ? "R4 rnd" : "R5 rnd");
    end
    @(posedge clk); #6;
    @(posedge clk); #6;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule